// File: doc/BRIEF.md
# Interrupt Request Aggregator

This block gathers a set of external interrupt request lines, normally 18 of them, and reduces them to one active-high level output toward a parent interrupt controller. Each request line is first brought into the local clock domain through a two-stage synchronizer. It is then adjusted by a per-line polarity bit and captured into a status bit. A single global control word decides whether every line is captured on edges or sampled as a level.

Software reaches the block through a simple 32-bit register port. Reads are combinational from the offset, and writes take effect at the clock edge on which the write strobe is high. The port exposes five registers: control, line enable, status, a write-one-to-clear port and line polarity. The cascade output is high whenever the controller is globally enabled and at least one enabled line has a pending status bit. A handler reads status and enable and clears what it has served.

Top module: `irq_aggregator`

## Requirements
- R1: Under reset the control register reads 0x8000_0000 (global enable on, level mode), enable reads 0, status reads 0, polarity reads 0x0003_FFFF (all lines active-high) and the cascade output is low.
- R2: Control sits at offset 0x00 and keeps only bit 31 (global enable) and bit 30 (1 = edge capture, 0 = level capture). Enable sits at 0x04 and polarity at 0x10, each using bits 17:0 with bit i for line i. Every unused bit reads as zero.
- R3: Status at 0x08 is read-only, so writing it changes nothing. The clear port at 0x0C always reads zero.
- R4: Any offset other than the five above, including offsets that are not word aligned, reads zero, and a write to it leaves every register unchanged.
- R5: Each request line passes through two synchronizer flops. In level mode, a change on a line that is applied before a rising edge shows in status after the third rising edge, and not after the second.
- R6: A polarity bit of 1 makes its line active when high. A polarity bit of 0 makes it active when low.
- R7: In level mode each status bit follows the synchronized, polarity-adjusted line, and writing a one to its clear bit has no lasting effect while the line stays active.
- R8: In edge mode a status bit sets when its adjusted line goes from inactive to active, and it stays set until cleared. A line held active after a clear does not set the bit again.
- R9: A write to the clear port clears exactly the status bits written as one and leaves the others untouched. Writing 0x3FFFF clears all of them.
- R10: The cascade output equals control bit 31 AND (the OR over all lines of enable AND status). It is combinational, so it follows a register write in the same cycle.
- R11: With control bit 31 at 0 the cascade output stays low, while status keeps capturing lines.
- R12: A pending line whose enable bit is 0 does not raise the cascade output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req_i | input | 18 | Asynchronous external request lines |
| irq_out | output | 1 | Active-high level request to the parent controller |

## Verification
The assertions take for granted that the write strobe and address are stable around the clock edge and that a write lasts a single cycle. They also assume that request lines, being asynchronous, only need to be seen after the synchronizer, so the capture checks relate status to the synchronized line and not to the raw pins. The bench drives the bus and the request lines only at falling edges and holds every request level or pulse for at least one full clock period. This keeps each change visible to the synchronizer, and the bench waits out the three-edge latency before it samples status.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int NUM_LINES = 18;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_ENA  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_STS  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_CLR  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_POL  = 6'h10;

    localparam int CTRL_EN_BIT   = 31;
    localparam int CTRL_EDGE_BIT = 30;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_ENA,
        SEL_STS,
        SEL_CLR,
        SEL_POL,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic {
        CAP_LEVEL = 1'b0,
        CAP_EDGE  = 1'b1
    } cap_mode_e;

    typedef struct packed {
        logic      glob_en;
        cap_mode_e mode;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{glob_en: 1'b1, mode: CAP_LEVEL};

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_CTRL: s = SEL_CTRL;
            OFF_ENA:  s = SEL_ENA;
            OFF_STS:  s = SEL_STS;
            OFF_CLR:  s = SEL_CLR;
            OFF_POL:  s = SEL_POL;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_EN_BIT]   = c.glob_en;
        w[CTRL_EDGE_BIT] = (c.mode == CAP_EDGE);
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.glob_en = w[CTRL_EN_BIT];
        c.mode    = w[CTRL_EDGE_BIT] ? CAP_EDGE : CAP_LEVEL;
        return c;
    endfunction

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int N      = irqagg_pkg::NUM_LINES,
    parameter int STAGES = irqagg_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    logic [N-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irqagg_capture.sv
module irqagg_capture
    import irqagg_pkg::*;
#(
    parameter int N = irqagg_pkg::NUM_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] pol_i,
    input  cap_mode_e    mode_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] sts_o
);

    logic [N-1:0] act;
    logic [N-1:0] prev_q;
    logic [N-1:0] sts_q;

    // polarity 1: high is active; polarity 0: low is active
    assign act = ~(line_i ^ pol_i);

    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q[i] <= 1'b0;
                    sts_q[i]  <= 1'b0;
                end else begin
                    prev_q[i] <= act[i];
                    if (mode_i == CAP_EDGE) begin
                        if (act[i] && !prev_q[i]) sts_q[i] <= 1'b1;
                        else if (clr_i[i])        sts_q[i] <= 1'b0;
                    end else begin
                        sts_q[i] <= act[i];
                    end
                end
            end
        end
    endgenerate

    assign sts_o = sts_q;

    // R8
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == CAP_EDGE) |=> ((($past(sts_q) & ~$past(clr_i)) & ~sts_q) == '0));

    // R8
    edge_set_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == CAP_EDGE) |=>
            ((sts_q & ~$past(sts_q) & ~($past(act) & ~$past(prev_q))) == '0));

    // R7
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == CAP_LEVEL) |=> (sts_q == $past(act)));

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int N = irqagg_pkg::NUM_LINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      sts_i,
    output ctrl_t             ctrl_o,
    output logic [N-1:0]      ena_o,
    output logic [N-1:0]      pol_o,
    output logic [N-1:0]      clr_o
);

    localparam int PAD_W = DATA_W - N;

    ctrl_t        ctrl_q;
    logic [N-1:0] ena_q;
    logic [N-1:0] pol_q;
    reg_sel_e     sel;
    logic         unused_wdata;

    assign sel = decode_offset(bus_addr);
    assign unused_wdata = ^bus_wdata[CTRL_EDGE_BIT-1:N];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            ena_q  <= '0;
            pol_q  <= '1;
        end else if (bus_wr) begin
            case (sel)
                SEL_CTRL: ctrl_q <= word_to_ctrl(bus_wdata);
                SEL_ENA:  ena_q  <= bus_wdata[N-1:0];
                SEL_POL:  pol_q  <= bus_wdata[N-1:0];
                default:  ;
            endcase
        end
    end

    assign clr_o = (bus_wr && sel == SEL_CLR) ? bus_wdata[N-1:0] : '0;

    always_comb begin
        case (sel)
            SEL_CTRL: bus_rdata = ctrl_to_word(ctrl_q);
            SEL_ENA:  bus_rdata = {{PAD_W{1'b0}}, ena_q};
            SEL_STS:  bus_rdata = {{PAD_W{1'b0}}, sts_i};
            SEL_POL:  bus_rdata = {{PAD_W{1'b0}}, pol_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign ena_o  = ena_q;
    assign pol_o  = pol_q;

    // R4
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_NONE) |=> ($stable(ctrl_q) && $stable(ena_q) && $stable(pol_q)));

    // R3
    status_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_STS) |=> ($stable(ctrl_q) && $stable(ena_q) && $stable(pol_q)));

    // R9
    clr_source_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_o != '0) |-> (bus_wr && bus_addr == OFF_CLR));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int N = irqagg_pkg::NUM_LINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      irq_req_i,
    output logic              irq_out
);

    logic [N-1:0] line_sync;
    logic [N-1:0] sts;
    logic [N-1:0] ena;
    logic [N-1:0] pol;
    logic [N-1:0] clr;
    ctrl_t        ctrl;

    irqagg_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (irq_req_i),
        .sync_o  (line_sync)
    );

    irqagg_capture #(.N(N)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_sync),
        .pol_i  (pol),
        .mode_i (ctrl.mode),
        .clr_i  (clr),
        .sts_o  (sts)
    );

    irqagg_regs #(.N(N)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sts_i     (sts),
        .ctrl_o    (ctrl),
        .ena_o     (ena),
        .pol_o     (pol),
        .clr_o     (clr)
    );

    assign irq_out = ctrl.glob_en && ((ena & sts) != '0);

    // R11
    glob_off_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rdata[0] || 1'b1 |-> (!ctrl.glob_en -> !irq_out));

    // R12
    no_enabled_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (ena == '0) |-> !irq_out);

endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [17:0] irq_req = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req_i (irq_req),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_lines(input logic [17:0] v);
        @(negedge clk);
        irq_req = v;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(6'h00, d); check("R1", "ctrl reset", d, 32'h8000_0000);
        rd(6'h04, d); check("R1", "enable reset", d, 32'h0);
        rd(6'h08, d); check("R1", "status reset", d, 32'h0);
        rd(6'h10, d); check("R1", "polarity reset", d, 32'h0003_FFFF);
        check("R1", "irq_out reset", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, d); check("R2", "ctrl keeps 31:30", d, 32'hC000_0000);
        wr(6'h00, 32'h8000_0000);
        wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, d); check("R2", "enable keeps 17:0", d, 32'h0003_FFFF);
        wr(6'h04, 32'h0);
        wr(6'h10, 32'h0001_2345); rd(6'h10, d); check("R2", "polarity readback", d, 32'h0001_2345);
        wr(6'h10, 32'h0003_FFFF);
    endtask

    task automatic t_readonly;
        logic [31:0] d;
        wr(6'h08, 32'h0003_FFFF); rd(6'h08, d); check("R3", "status write ignored", d, 32'h0);
        rd(6'h0C, d); check("R3", "clear port reads zero", d, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(6'h14, 32'hFFFF_FFFF);
        wr(6'h3C, 32'hFFFF_FFFF);
        wr(6'h05, 32'hFFFF_FFFF);
        wr(6'h02, 32'h0000_0000);
        rd(6'h14, d); check("R4", "unmapped 0x14 reads zero", d, 32'h0);
        rd(6'h05, d); check("R4", "unaligned 0x05 reads zero", d, 32'h0);
        rd(6'h04, d); check("R4", "enable untouched", d, 32'h0);
        rd(6'h10, d); check("R4", "polarity untouched", d, 32'h0003_FFFF);
        rd(6'h00, d); check("R4", "ctrl untouched", d, 32'h8000_0000);
    endtask

    task automatic t_latency_level;
        logic [31:0] d;
        set_lines(18'h00008);
        settle(2);
        @(negedge clk); bus_addr = 6'h08; #1 d = bus_rdata;
        check("R5", "status not yet after two edges", d, 32'h0);
        d = 32'h0;
        @(posedge clk); #1 d = bus_rdata;
        check("R5", "status after three edges", d, 32'h0000_0008);
        wr(6'h0C, 32'h0000_0008);
        rd(6'h08, d); check("R7", "level clear has no effect while active", d, 32'h0000_0008);
        set_lines(18'h0); settle(4);
        rd(6'h08, d); check("R7", "level status follows line low", d, 32'h0);
    endtask

    task automatic t_polarity;
        logic [31:0] d;
        wr(6'h10, 32'h0003_FFDF);
        settle(3);
        rd(6'h08, d); check("R6", "active-low line idle low is pending", d, 32'h0000_0020);
        set_lines(18'h00020); settle(4);
        rd(6'h08, d); check("R6", "active-low line driven high not pending", d, 32'h0);
        wr(6'h10, 32'h0003_FFFF);
        settle(2);
        rd(6'h08, d); check("R6", "active-high line driven high pending", d, 32'h0000_0020);
        set_lines(18'h0); settle(4);
    endtask

    task automatic t_edge;
        logic [31:0] d;
        wr(6'h00, 32'hC000_0000);
        wr(6'h0C, 32'h0003_FFFF);
        set_lines(18'h00080); settle(2);
        set_lines(18'h0); settle(5);
        rd(6'h08, d); check("R8", "edge captured and held after pulse", d, 32'h0000_0080);
        wr(6'h0C, 32'h0000_0001);
        rd(6'h08, d); check("R9", "clearing another line keeps bit 7", d, 32'h0000_0080);
        wr(6'h0C, 32'h0000_0080);
        rd(6'h08, d); check("R9", "clearing bit 7", d, 32'h0);
        set_lines(18'h00100); settle(4);
        rd(6'h08, d); check("R8", "edge while held", d, 32'h0000_0100);
        wr(6'h0C, 32'h0000_0100); settle(3);
        rd(6'h08, d); check("R8", "held line does not re-set", d, 32'h0);
        set_lines(18'h0); settle(4);
        set_lines(18'h20003); settle(2);
        set_lines(18'h0); settle(5);
        rd(6'h08, d); check("R8", "three lines captured", d, 32'h0002_0003);
        wr(6'h0C, 32'h0000_0002);
        rd(6'h08, d); check("R9", "only bit 1 cleared", d, 32'h0002_0001);
        wr(6'h0C, 32'h0003_FFFF);
        rd(6'h08, d); check("R9", "clear all", d, 32'h0);
        wr(6'h00, 32'h8000_0000);
        settle(2);
    endtask

    task automatic t_cascade;
        logic [31:0] d;
        set_lines(18'h00204); settle(4);
        rd(6'h08, d); check("R12", "lines pending", d, 32'h0000_0204);
        check("R12", "no enable, no output", {31'b0, irq_out}, 32'h0);
        wr(6'h04, 32'h0000_0004);
        check("R10", "output follows enable write", {31'b0, irq_out}, 32'h1);
        wr(6'h00, 32'h0000_0000);
        check("R11", "global disable drops output", {31'b0, irq_out}, 32'h0);
        set_lines(18'h00214); settle(4);
        rd(6'h08, d); check("R11", "status captures while disabled", d, 32'h0000_0214);
        check("R11", "output still low", {31'b0, irq_out}, 32'h0);
        wr(6'h00, 32'h8000_0000);
        check("R10", "re-enable raises output", {31'b0, irq_out}, 32'h1);
        wr(6'h04, 32'h0000_0200);
        check("R10", "other enabled line keeps output", {31'b0, irq_out}, 32'h1);
        wr(6'h04, 32'h0000_0001);
        check("R12", "idle enabled line only", {31'b0, irq_out}, 32'h0);
        set_lines(18'h0); settle(4);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_regs();
        t_readonly();
        t_unmapped();
        t_latency_level();
        t_polarity();
        t_edge();
        t_cascade();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule